// File: doc/BRIEF.md
# Shared-Pool Multi-Queue FIFO Controller

This block carves a single on-chip word memory into up to eight independent first-in first-out queues, all in one clock domain. The pool is made of fixed-size segments. When master reset is held, the block samples how many queues are wanted and gives each active queue an equal whole number of segments. Each queue has its own region of the pool. Its read and write offsets wrap inside that region, and it keeps an occupancy count.

The write side picks a queue with `wr_q` and pushes `wr_data` when `wr_en` is high. The read side picks a queue on its own with `rd_q`. It shows that queue's head word with `rd_valid` and no extra read cycle, and pops the word when `rd_en` is high while `rd_valid` is set. One push and one pop can happen in the same cycle on different queues or on the same queue. Per-queue almost-empty and almost-full offsets can be changed through a small register-write port. Any one queue can be emptied by a partial reset while the other queues keep their data. The almost flags of every queue are driven at all times on two 8-bit vectors.

Top module: `mq_fifo_ctrl`

## Requirements
- R1: While `rst_n` is low, `cfg_qcount` is sampled. A value n from 1 to 7 activates queues 0..n-1, and 0 activates all 8 queues. An inactive queue ignores writes, reports `full_o`=1, reads 1 in `pae_vec` and reads 0 in `paf_vec`.
- R2: Each active queue holds floor(NUM_SEGS / n) * SEG_WORDS words and accepts exactly that many before it reports full.
- R3: Each queue returns its words in write order, including after its offsets wrap around the end of its region.
- R4: In one cycle, a push to one queue and a pop from another both take effect.
- R5: With `rd_q` unchanged, a word pushed into an empty queue at clock edge t shows on `rd_data` with `rd_valid`=1 right after edge t. After a pop at edge t, the next word (or `rd_valid`=0) shows right after edge t.
- R6: In the cycle right after `rd_q` changes, `rd_valid` is 0. From the next clock edge on, it reflects the newly selected queue.
- R7: `full_o` is the full state of queue `wr_q`. A push to a full queue is dropped and changes no stored word, offset or count.
- R8: A pop request while `rd_valid`=0 has no effect.
- R9: `pae_vec[n]` is 1 when queue n's count is at or below its almost-empty offset (default DEF_AE_OFF). `pae_o` is that bit for queue `rd_q`.
- R10: `paf_vec[n]` is 1 when queue n's count plus its almost-full offset (default DEF_AF_OFF) reaches its capacity. `paf_o` is that bit for queue `wr_q`.
- R11: A cycle with `thr_we`=1 loads `thr_val` into queue `thr_q`'s almost-empty offset (`thr_sel`=0) or almost-full offset (`thr_sel`=1). The new offset governs the flags from the next edge on.
- R12: `prst`=1 empties queue `prst_q`, and it overrides a push or pop to that queue in the same cycle. The other queues keep their contents and the emptied queue keeps its offsets.
- R13: After master reset, every queue is empty, `rd_valid`=0 and all offsets hold their defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| cfg_qcount | input | 3 | Number of queues, sampled during reset (0 means 8) |
| wr_en | input | 1 | Push request |
| wr_q | input | 3 | Queue selected for push |
| wr_data | input | DW | Word to push |
| full_o | output | 1 | Selected write queue is full |
| paf_o | output | 1 | Selected write queue is almost full |
| rd_en | input | 1 | Pop request |
| rd_q | input | 3 | Queue selected for reading |
| rd_data | output | DW | Head word of the selected read queue |
| rd_valid | output | 1 | `rd_data` holds a valid head word |
| pae_o | output | 1 | Selected read queue is almost empty |
| prst | input | 1 | Partial reset strobe |
| prst_q | input | 3 | Queue to empty |
| thr_we | input | 1 | Offset register write strobe |
| thr_q | input | 3 | Queue whose offset is written |
| thr_sel | input | 1 | 0 = almost-empty offset, 1 = almost-full offset |
| thr_val | input | CW | Offset value |
| pae_vec | output | 8 | Almost-empty flag of every queue |
| paf_vec | output | 8 | Almost-full flag of every queue |

## Verification
The checks on offsets and counts assume that reset is held for at least one clock edge before use. They also assume that `rd_q` and `wr_q` change only between edges. The offset-register port is assumed to write a queue only while nothing pushes to or pops from it, so the offsets never move under a live count. The bench changes every input on the falling edge, holds reset for three cycles, and loads offsets only into queues that are idle at that moment. Write and read selects move freely, including onto full, empty and inactive queues.

// File: rtl/mq_pkg.sv
// Package: constants and types shared by the multi-queue controller.
package mq_pkg;
    localparam int MAX_Q = 8;
    localparam int QW    = 3;
    typedef enum logic {THR_AE = 1'b0, THR_AF = 1'b1} thr_sel_e;
endpackage

// File: rtl/mq_layout.sv
// mq_layout: latches the queue count during master reset and derives
// each queue's region (base word and span) in the shared pool.
// Assumes NUM_SEGS >= MAX_Q so that every queue gets at least one segment.
module mq_layout #(
    parameter int NUM_SEGS  = 16,
    parameter int SEG_WORDS = 64,
    parameter int AW        = 10,
    parameter int CW        = 11
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [mq_pkg::QW-1:0]              cfg_qcount,
    output logic [mq_pkg::MAX_Q-1:0]           active,
    output logic [CW-1:0]                      span,
    output logic [mq_pkg::MAX_Q-1:0][AW-1:0]   base
);
    localparam int QN   = mq_pkg::MAX_Q;
    localparam int POOL = NUM_SEGS * SEG_WORDS;

    logic [3:0]  nq_r;
    logic [31:0] seg_per_q;

    // Sample the requested queue count while master reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n)
            nq_r <= (cfg_qcount == '0) ? 4'd8 : {1'b0, cfg_qcount};
    end

    // Equal split of the pool in whole segments.
    always_comb begin
        seg_per_q = 32'(NUM_SEGS) / 32'(nq_r);
        span      = CW'(seg_per_q * 32'(SEG_WORDS));
    end

    for (genvar g = 0; g < QN; g++) begin : g_region
        assign base[g]   = AW'(32'(g) * 32'(span));
        assign active[g] = (4'(g) < nq_r);
    end

    // R2
    layout_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nq_r >= 4'd1) && (nq_r <= 4'd8) && (32'(nq_r) * 32'(span) <= 32'(POOL)));
endmodule

// File: rtl/mq_queue_ctrl.sv
// mq_queue_ctrl: per-queue state. It keeps the write and read offsets inside
// the queue's region, the occupancy count, the two flag offsets and the flags.
// Assumes wr_go is never raised while full and rd_go only while count > 0.
module mq_queue_ctrl #(
    parameter int CW     = 11,
    parameter int DEF_AE = 1,
    parameter int DEF_AF = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic [CW-1:0] cap,
    input  logic          wr_go,
    input  logic          rd_go,
    input  logic          clr,
    input  logic          ae_we,
    input  logic          af_we,
    input  logic [CW-1:0] thr_val,
    output logic [CW-1:0] wofs,
    output logic [CW-1:0] rofs,
    output logic [CW-1:0] rofs_nx,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cnt_nx,
    output logic          full,
    output logic          pae,
    output logic          paf
);
    logic          wr_do, rd_do;
    logic [CW-1:0] wofs_nx;
    logic [CW-1:0] ae_off, af_off;

    function automatic logic [CW-1:0] step(input logic [CW-1:0] o, input logic [CW-1:0] c);
        return (o == c - 1'b1) ? '0 : o + 1'b1;
    endfunction

    // Next offsets and count; a partial reset beats push and pop.
    always_comb begin
        wr_do   = wr_go && !clr;
        rd_do   = rd_go && !clr;
        wofs_nx = clr ? '0 : (wr_do ? step(wofs, cap) : wofs);
        rofs_nx = clr ? '0 : (rd_do ? step(rofs, cap) : rofs);
        case ({wr_do, rd_do})
            2'b10:   cnt_nx = cnt + 1'b1;
            2'b01:   cnt_nx = cnt - 1'b1;
            default: cnt_nx = cnt;
        endcase
        if (clr) cnt_nx = '0;
    end

    // Offset and count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wofs <= '0;
            rofs <= '0;
            cnt  <= '0;
        end else begin
            wofs <= wofs_nx;
            rofs <= rofs_nx;
            cnt  <= cnt_nx;
        end
    end

    // Flag offset registers, loaded through the register-write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ae_off <= CW'(DEF_AE);
            af_off <= CW'(DEF_AF);
        end else begin
            if (ae_we) ae_off <= thr_val;
            if (af_we) af_off <= thr_val;
        end
    end

    // Flags; an inactive queue looks full for writes and empty for reads.
    always_comb begin
        full = !active || (cnt == cap);
        pae  = !active || (cnt <= ae_off);
        paf  = active && (({1'b0, cnt} + {1'b0, af_off}) >= {1'b0, cap});
    end

    logic [CW-1:0] gap;
    always_comb gap = (wofs >= rofs) ? (wofs - rofs) : (wofs + cap - rofs);

    // R7
    cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt <= cap));
    // R3
    ofs_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> ((wofs < cap) && (rofs < cap)));
    // R3
    ofs_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (gap == ((cnt == cap) ? '0 : cnt)));
    // R12
    prst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((cnt == '0) && (wofs == '0) && (rofs == '0)));
endmodule

// File: rtl/mq_pool_mem.sv
// mq_pool_mem: shared word pool with one write port and one registered read
// port. A write to the address being read in the same cycle is forwarded.
module mq_pool_mem #(
    parameter int DW    = 18,
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Store pushed words.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered head read with write-through forwarding.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else
            rdata <= (we && (waddr == raddr)) ? wdata : mem[raddr];
    end
endmodule

// File: rtl/mq_fifo_ctrl.sv
// mq_fifo_ctrl: top of the shared-pool multi-queue controller. It selects
// queues for push and pop, gates requests by the flags, keeps the
// look-ahead head register and gathers the per-queue flag vectors.
// Assumes rd_q and wr_q are stable around each rising edge.
module mq_fifo_ctrl #(
    parameter int DW         = 18,
    parameter int NUM_SEGS   = 16,
    parameter int SEG_WORDS  = 64,
    parameter int DEF_AE_OFF = 1,
    parameter int DEF_AF_OFF = 1,
    localparam int POOL      = NUM_SEGS * SEG_WORDS,
    localparam int AW        = $clog2(POOL),
    localparam int CW        = $clog2(POOL + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            cfg_qcount,
    input  logic                  wr_en,
    input  logic [2:0]            wr_q,
    input  logic [DW-1:0]         wr_data,
    output logic                  full_o,
    output logic                  paf_o,
    input  logic                  rd_en,
    input  logic [2:0]            rd_q,
    output logic [DW-1:0]         rd_data,
    output logic                  rd_valid,
    output logic                  pae_o,
    input  logic                  prst,
    input  logic [2:0]            prst_q,
    input  logic                  thr_we,
    input  logic [2:0]            thr_q,
    input  logic                  thr_sel,
    input  logic [CW-1:0]         thr_val,
    output logic [7:0]            pae_vec,
    output logic [7:0]            paf_vec
);
    import mq_pkg::*;
    localparam int QN = MAX_Q;
    localparam int SW = CW + 1;

    logic [QN-1:0]         active;
    logic [CW-1:0]         span;
    logic [QN-1:0][AW-1:0] base;

    logic [CW-1:0] wofs_q [QN];
    logic [CW-1:0] rofs_q [QN];
    logic [CW-1:0] rnx_q  [QN];
    logic [CW-1:0] cnt_q  [QN];
    logic [CW-1:0] cnx_q  [QN];
    logic [QN-1:0] full_v, pae_v, paf_v;
    logic [QN-1:0] wr_go, rd_go, clr, ae_we, af_we;

    logic          wr_fire, rd_fire;
    logic [AW-1:0] waddr, raddr;
    logic [2:0]    out_q_r;
    logic          out_ok_r;

    mq_layout #(.NUM_SEGS(NUM_SEGS), .SEG_WORDS(SEG_WORDS), .AW(AW), .CW(CW)) u_layout (
        .clk(clk), .rst_n(rst_n), .cfg_qcount(cfg_qcount),
        .active(active), .span(span), .base(base)
    );

    // Head word is valid only once the register tracks the current select.
    always_comb begin
        rd_valid = out_ok_r && (out_q_r == rd_q);
        wr_fire  = wr_en && !full_v[wr_q];
        rd_fire  = rd_en && rd_valid;
    end

    for (genvar g = 0; g < QN; g++) begin : g_queue
        // Per-queue strobes decoded from the shared selects.
        always_comb begin
            wr_go[g] = wr_fire && (wr_q == 3'(g));
            rd_go[g] = rd_fire && (rd_q == 3'(g));
            clr[g]   = prst && (prst_q == 3'(g));
            ae_we[g] = thr_we && (thr_q == 3'(g)) && (thr_sel == THR_AE);
            af_we[g] = thr_we && (thr_q == 3'(g)) && (thr_sel == THR_AF);
        end

        mq_queue_ctrl #(.CW(CW), .DEF_AE(DEF_AE_OFF), .DEF_AF(DEF_AF_OFF)) u_q (
            .clk(clk), .rst_n(rst_n), .active(active[g]), .cap(span),
            .wr_go(wr_go[g]), .rd_go(rd_go[g]), .clr(clr[g]),
            .ae_we(ae_we[g]), .af_we(af_we[g]), .thr_val(thr_val),
            .wofs(wofs_q[g]), .rofs(rofs_q[g]), .rofs_nx(rnx_q[g]),
            .cnt(cnt_q[g]), .cnt_nx(cnx_q[g]),
            .full(full_v[g]), .pae(pae_v[g]), .paf(paf_v[g])
        );
    end

    // Pool addresses: region base plus offset.
    always_comb begin
        waddr = AW'(SW'(base[wr_q]) + SW'(wofs_q[wr_q]));
        raddr = AW'(SW'(base[rd_q]) + SW'(rnx_q[rd_q]));
    end

    mq_pool_mem #(.DW(DW), .DEPTH(POOL), .AW(AW)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(wr_fire && !clr[wr_q]), .waddr(waddr),
        .wdata(wr_data), .raddr(raddr), .rdata(rd_data)
    );

    // Track which queue the head register holds and whether it is non-empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q_r  <= '0;
            out_ok_r <= 1'b0;
        end else begin
            out_q_r  <= rd_q;
            out_ok_r <= (cnx_q[rd_q] != '0);
        end
    end

    // Selected-queue flags and all-queue vectors.
    always_comb begin
        full_o  = full_v[wr_q];
        paf_o   = paf_v[wr_q];
        pae_o   = pae_v[rd_q];
        pae_vec = pae_v;
        paf_vec = paf_v;
    end

    // R6
    sel_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_q) |-> !rd_valid);
    // R5
    valid_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (cnt_q[rd_q] != '0));
    // R1
    inactive_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active[wr_q] |-> full_o);
endmodule

// File: tb/mq_fifo_ctrl_tb.sv
`timescale 1ns/1ps
module mq_fifo_ctrl_tb;
    localparam int DW = 18, NS = 16, SWD = 4;
    localparam int CW = $clog2(NS * SWD + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] cfg_qcount = '0;
    logic wr_en = 1'b0, rd_en = 1'b0, prst = 1'b0, thr_we = 1'b0, thr_sel = 1'b0;
    logic [2:0] wr_q = '0, rd_q = '0, prst_q = '0, thr_q = '0;
    logic [DW-1:0] wr_data = '0;
    logic [CW-1:0] thr_val = '0;
    logic full_o, paf_o, rd_valid, pae_o;
    logic [DW-1:0] rd_data;
    logic [7:0] pae_vec, paf_vec;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    mq_fifo_ctrl #(.DW(DW), .NUM_SEGS(NS), .SEG_WORDS(SWD)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_qcount(cfg_qcount),
        .wr_en(wr_en), .wr_q(wr_q), .wr_data(wr_data), .full_o(full_o), .paf_o(paf_o),
        .rd_en(rd_en), .rd_q(rd_q), .rd_data(rd_data), .rd_valid(rd_valid), .pae_o(pae_o),
        .prst(prst), .prst_q(prst_q), .thr_we(thr_we), .thr_q(thr_q), .thr_sel(thr_sel),
        .thr_val(thr_val), .pae_vec(pae_vec), .paf_vec(paf_vec)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [2:0] n);
        rst_n = 1'b0;
        cfg_qcount = n;
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    task automatic push(input int q, input int d);
        wr_en = 1'b1; wr_q = 3'(q); wr_data = DW'(d);
        tick();
        wr_en = 1'b0;
    endtask

    task automatic pop_chk(input int exp, input string tag);
        chk(rd_valid == 1'b1, {tag, " valid"}, int'(rd_valid), 1);
        chk(rd_data == DW'(exp), {tag, " data"}, int'(rd_data), exp);
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        chk(pae_vec == 8'hff, "R13 pae_vec", int'(pae_vec), 8'hff);
        chk(paf_vec == 8'h00, "R13 paf_vec", int'(paf_vec), 0);
        chk(rd_valid == 1'b0, "R13 rd_valid", int'(rd_valid), 0);
        chk(full_o == 1'b0, "R13 full_o", int'(full_o), 0);
    endtask

    task automatic t_fwft();
        rd_q = 3'd0;
        push(0, 'h11);
        chk(rd_valid && rd_data == DW'('h11), "R5 fall-through", int'(rd_data), 'h11);
        push(0, 'h22);
        pop_chk('h11, "R5 first");
        pop_chk('h22, "R5 second");
        chk(rd_valid == 1'b0, "R5 empty after pops", int'(rd_valid), 0);
    endtask

    task automatic t_select();
        push(1, 'h1a);
        push(3, 'h3b);
        rd_q = 3'd1; #1;
        chk(rd_valid == 1'b0, "R6 valid low on change", int'(rd_valid), 0);
        @(negedge clk);
        chk(rd_valid && rd_data == DW'('h1a), "R6 q1 head", int'(rd_data), 'h1a);
        rd_q = 3'd3; #1;
        chk(rd_valid == 1'b0, "R6 valid low on change", int'(rd_valid), 0);
        @(negedge clk);
        pop_chk('h3b, "R6 q3");
        rd_q = 3'd1; tick();
        pop_chk('h1a, "R6 q1");
    endtask

    task automatic t_full();
        for (int i = 0; i < 8; i++) begin
            push(2, 'h200 + i);
            if (i == 0) chk(pae_vec[2] == 1'b1, "R9 pae at 1", int'(pae_vec[2]), 1);
            if (i == 1) chk(pae_vec[2] == 1'b0, "R9 pae at 2", int'(pae_vec[2]), 0);
            if (i == 5) chk(paf_vec[2] == 1'b0, "R10 paf at 6", int'(paf_vec[2]), 0);
            if (i == 6) chk(paf_o == 1'b1, "R10 paf_o at 7", int'(paf_o), 1);
            if (i == 6) chk(full_o == 1'b0, "R7 not full at 7", int'(full_o), 0);
        end
        chk(full_o == 1'b1, "R2 R7 full at 8", int'(full_o), 1);
        push(2, 'h3ff);
        rd_q = 3'd2; tick();
        for (int i = 0; i < 8; i++) pop_chk('h200 + i, "R7 R3 drain q2");
        chk(rd_valid == 1'b0, "R7 dropped word absent", int'(rd_valid), 0);
        for (int i = 0; i < 5; i++) push(2, 'h210 + i);
        for (int i = 0; i < 5; i++) pop_chk('h210 + i, "R3 wrapped order");
    endtask

    task automatic t_read_empty();
        rd_q = 3'd2; rd_en = 1'b1;
        repeat (2) tick();
        rd_en = 1'b0;
        push(2, 'h2aa);
        chk(rd_valid && rd_data == DW'('h2aa), "R8 no underflow", int'(rd_data), 'h2aa);
        chk(pae_o == 1'b1, "R9 pae_o count1", int'(pae_o), 1);
        pop_chk('h2aa, "R8 pop");
        chk(rd_valid == 1'b0, "R8 empty again", int'(rd_valid), 0);
    endtask

    task automatic t_concurrent();
        for (int i = 0; i < 4; i++) push(5, 'h500 + i);
        rd_q = 3'd5; tick();
        for (int i = 0; i < 4; i++) begin
            chk(rd_valid && rd_data == DW'('h500 + i), "R4 read q5", int'(rd_data), 'h500 + i);
            wr_en = 1'b1; wr_q = 3'd4; wr_data = DW'('h400 + i); rd_en = 1'b1;
            tick();
        end
        wr_en = 1'b0; rd_en = 1'b0;
        chk(rd_valid == 1'b0, "R4 q5 drained", int'(rd_valid), 0);
        rd_q = 3'd4; tick();
        for (int i = 0; i < 4; i++) pop_chk('h400 + i, "R4 q4 contents");
    endtask

    task automatic t_thresh();
        thr_we = 1'b1; thr_q = 3'd4; thr_sel = 1'b0; thr_val = CW'(3);
        tick();
        thr_sel = 1'b1; thr_val = CW'(4);
        tick();
        thr_we = 1'b0;
        for (int i = 0; i < 3; i++) push(4, 'h4c0 + i);
        chk(pae_vec[4] == 1'b1, "R11 pae at 3 with offset 3", int'(pae_vec[4]), 1);
        chk(paf_vec[4] == 1'b0, "R11 paf at 3 with offset 4", int'(paf_vec[4]), 0);
        push(4, 'h4c3);
        chk(pae_vec[4] == 1'b0, "R11 pae at 4", int'(pae_vec[4]), 0);
        chk(paf_vec[4] == 1'b1, "R11 paf at 4", int'(paf_vec[4]), 1);
    endtask

    task automatic t_prst();
        push(6, 'h600);
        push(6, 'h601);
        prst = 1'b1; prst_q = 3'd4; wr_en = 1'b1; wr_q = 3'd4; wr_data = DW'('h4ff);
        tick();
        prst = 1'b0; wr_en = 1'b0;
        chk(pae_vec[4] == 1'b1 && paf_vec[4] == 1'b0, "R12 q4 flags empty",
            int'({paf_vec[4], pae_vec[4]}), 1);
        rd_q = 3'd4; tick();
        chk(rd_valid == 1'b0, "R12 q4 empty", int'(rd_valid), 0);
        rd_q = 3'd6; tick();
        pop_chk('h600, "R12 q6 kept");
        pop_chk('h601, "R12 q6 kept");
        push(4, 'h4aa);
        rd_q = 3'd4; tick();
        pop_chk('h4aa, "R12 q4 reusable");
    endtask

    task automatic t_cfg();
        do_reset(3'd3);
        chk(pae_vec == 8'hff && paf_vec == 8'h00, "R1 R13 vectors",
            int'({paf_vec, pae_vec}), 'hff);
        wr_q = 3'd5; #1;
        chk(full_o == 1'b1, "R1 inactive full", int'(full_o), 1);
        push(5, 'h5ee);
        rd_q = 3'd5; tick();
        chk(rd_valid == 1'b0, "R1 inactive write ignored", int'(rd_valid), 0);
        for (int i = 0; i < 20; i++) begin
            push(1, 'h100 + i);
            if (i == 18) chk(full_o == 1'b0, "R2 not full at 19", int'(full_o), 0);
        end
        chk(full_o == 1'b1, "R2 full at 20", int'(full_o), 1);
        push(1, 'h1ff);
        rd_q = 3'd1; tick();
        for (int i = 0; i < 20; i++) pop_chk('h100 + i, "R2 q1 contents");
        chk(rd_valid == 1'b0, "R2 R7 overflow dropped", int'(rd_valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset(3'd0);
        t_reset();
        t_fwft();
        t_select();
        t_full();
        t_read_empty();
        t_concurrent();
        t_thresh();
        t_prst();
        t_cfg();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule